// File: doc/BRIEF.md
# Serial Target Front-End with Pause

This block is the pin-facing half of a serial memory-style peripheral. It watches a chip-select, a serial clock, a serial data input and a pause input. It assembles incoming bits into bytes, most-significant bit first, and hands each finished byte to downstream control logic with a one-cycle strobe. The first byte after selection is marked as the opcode. In the other direction, the controller places reply bytes in a holding register. At each byte boundary the front-end moves the held byte into a shifter and drives it out one bit per serial clock, with a separate output-enable for the tri-state pad.

The pins are oversampled by the system clock through synchronisers, so every serial event becomes a single-cycle pulse. The serial clock may rest low or high while the target is deselected. Input bits are taken on rising edges and output bits move on falling edges in both cases.

The pause function freezes a transfer in place without deselecting the target. Entry and exit only take effect while the serial clock is low. Deselecting during a pause, or in the middle of a byte, cancels the sequence and raises an abort pulse.

Top module: `spi_target_fe`

## Requirements
- R1: While reset is held low, `rx_valid`, `rx_first`, `xfer_start`, `xfer_abort`, `tx_taken` and `miso_oe` are all 0.
- R2: Each eight sampled rising serial-clock edges inside a selection produce exactly one single-cycle `rx_valid`, with `rx_byte` holding the eight `mosi` bits: the first sampled bit is in bit 7 and the last in bit 0.
- R3: `rx_first` is 1 together with the first `rx_valid` after chip-select falls, and 0 for every later byte of that selection.
- R4: Each falling edge of `cs_n` produces one single-cycle `xfer_start` pulse.
- R5: Resting the serial clock low or high while deselected yields identical received and transmitted bytes.
- R6: While `tx_req` is 1, the first falling serial-clock edge after a completed byte loads the reply byte and pulses `tx_taken`. The byte goes out MSB first: `miso` presents bit 7 after that falling edge and advances one bit per later falling edge. `miso_oe` is 1 only while a reply byte is being shifted. With `tx_req` at 0, the output stays disabled at that boundary.
- R7: When no `tx_load` arrives between two boundaries, the previously held reply byte is sent again. A `tx_load` in the loading cycle itself is used at once.
- R8: With `cs_n` low, `hold_n` low and the serial clock low, the block pauses. While paused, `miso_oe` is 0, clock and data activity is ignored, and no byte completes. After the pause ends, the transfer resumes at the exact bit where it stopped.
- R9: A change of `hold_n` made while the serial clock is high takes effect only at the next clock-low level. The falling clock edge that starts a pause is still processed; the one that ends a pause is not.
- R10: `cs_n` rising while paused, or with a partly received byte, gives one `xfer_abort` pulse and clears the bit position. The next selection starts a fresh byte flagged as the opcode. A deselect on a byte boundary while not paused gives no abort.
- R11: While `cs_n` is high, `miso_oe` is 0 and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the target |
| hold_n | input | 1 | Pause request, active low |
| tx_data | input | BYTE_W | Reply byte from the controller |
| tx_load | input | 1 | Writes `tx_data` into the reply holding register |
| tx_req | input | 1 | Controller wants a reply byte shifted at the next boundary |
| miso | output | 1 | Serial data out of the target |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| rx_byte | output | BYTE_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` is new |
| rx_first | output | 1 | The strobed byte is the opcode of the selection |
| xfer_start | output | 1 | One-cycle pulse on selection |
| xfer_abort | output | 1 | One-cycle pulse on an interrupted selection |
| tx_taken | output | 1 | One-cycle pulse when a reply byte enters the shifter |

## Verification
Two things can happen in the same cycle: pause entry and a falling serial-clock edge that loads or shifts the reply. This happens when `hold_n` drops while the clock is high and the clock then falls. The falling edge must be acted on exactly once, and the pause must then hide the output. The bench provokes this in the idle-high mode on the first bit of a reply byte and on other bits. It judges the result by reassembling the whole reply byte after the pause is released and comparing it with the loaded value. The received bytes go through a queue-based scoreboard, so a lost or duplicated bit shows up as a corrupted or extra byte.

// File: rtl/spi_fe_pkg.sv
// Package: shared types for the serial target front-end.
// Assumes: pin event record is produced once per system clock cycle.
package spi_fe_pkg;

    // Index of each serial pin inside the synchroniser vector
    localparam int unsigned PIN_CS   = 0;
    localparam int unsigned PIN_SCK  = 1;
    localparam int unsigned PIN_MOSI = 2;
    localparam int unsigned PIN_HOLD = 3;
    localparam int unsigned PIN_CNT  = 4;

    // Synchronised pin levels and single-cycle edge events
    typedef struct packed {
        logic cs_act;    // chip-select asserted (cs_n low)
        logic sck_lvl;   // serial clock level
        logic mosi_lvl;  // serial data level
        logic hold_act;  // pause requested (hold_n low)
        logic sck_rise;  // serial clock went high this cycle
        logic sck_fall;  // serial clock went low this cycle
        logic cs_fall;   // selection began this cycle
        logic cs_rise;   // selection ended this cycle
    } pin_evt_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the four asynchronous serial pins into the clk domain through
// SYNC_STAGES flops each and derives single-cycle edge events for the
// serial clock and chip-select.
// Assumes: SYNC_STAGES >= 2 and each serial clock phase lasts at least
// two clk cycles.
module spi_pin_sync
    import spi_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     mosi,
    input  logic     hold_n,
    output pin_evt_t evt
);

    // Reset levels: deselected, not paused
    localparam logic [PIN_CNT-1:0] RST_VAL = 4'b1001;

    logic [PIN_CNT-1:0] raw;
    logic [PIN_CNT-1:0] lvl;
    logic               sck_q;
    logic               cs_q;

    assign raw[PIN_CS]   = cs_n;
    assign raw[PIN_SCK]  = sck;
    assign raw[PIN_MOSI] = mosi;
    assign raw[PIN_HOLD] = hold_n;

    for (genvar g = 0; g < PIN_CNT; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;

        // Shift the raw pin level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {SYNC_STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
        end

        assign lvl[g] = chain[SYNC_STAGES-1];
    end

    // Keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= lvl[PIN_SCK];
            cs_q  <= lvl[PIN_CS];
        end
    end

    // Pack levels and edges into the event record
    always_comb begin
        evt.cs_act   = ~lvl[PIN_CS];
        evt.sck_lvl  = lvl[PIN_SCK];
        evt.mosi_lvl = lvl[PIN_MOSI];
        evt.hold_act = ~lvl[PIN_HOLD];
        evt.sck_rise = lvl[PIN_SCK] & ~sck_q;
        evt.sck_fall = ~lvl[PIN_SCK] & sck_q;
        evt.cs_fall  = ~lvl[PIN_CS] & cs_q;
        evt.cs_rise  = lvl[PIN_CS] & ~cs_q;
    end

endmodule

// File: rtl/spi_hold_ctrl.sv
// Module: spi_hold_ctrl
// Tracks the pause state. The pause request is only sampled while the
// serial clock is low, so a request made during the high phase takes
// effect at the next low level. Deselection clears the pause.
// Assumes: inputs come from spi_pin_sync.
module spi_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic sck_lvl,
    input  logic hold_act,
    output logic paused
);

    // Follow the pause request during clock-low phases of a selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
        end else if (!cs_act) begin
            paused <= 1'b0;
        end else if (!sck_lvl) begin
            paused <= hold_act;
        end
    end

endmodule

// File: rtl/spi_rx_shift.sv
// Module: spi_rx_shift
// Assembles serial input bits, MSB first, on unpaused rising clock
// edges. Emits a byte strobe with an opcode flag, a start pulse on
// selection and an abort pulse when deselection interrupts a pause or
// a partial byte.
// Assumes: edge events are single-cycle pulses from spi_pin_sync.
module spi_rx_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              mosi_lvl,
    input  logic              paused,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              xfer_start,
    output logic              xfer_abort
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              first_pend;
    logic              rise_ok;
    logic [BYTE_W-1:0] shreg_nxt;

    assign rise_ok   = sck_rise & cs_act & ~paused;
    assign shreg_nxt = {shreg[BYTE_W-2:0], mosi_lvl};

    // Transaction start and abort pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_start <= 1'b0;
            xfer_abort <= 1'b0;
        end else begin
            xfer_start <= cs_fall;
            xfer_abort <= cs_rise & (paused | (bit_cnt != '0));
        end
    end

    // Bit position and opcode tracking across a selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            first_pend <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt    <= '0;
            first_pend <= 1'b0;
        end else if (cs_fall) begin
            bit_cnt    <= '0;
            first_pend <= 1'b1;
        end else if (rise_ok) begin
            if (bit_cnt == LAST_BIT) begin
                bit_cnt    <= '0;
                first_pend <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Shift register and completed-byte output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
            if (rise_ok) begin
                shreg <= shreg_nxt;
                if (bit_cnt == LAST_BIT) begin
                    rx_byte  <= shreg_nxt;
                    rx_valid <= 1'b1;
                    rx_first <= first_pend;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
// Module: spi_tx_shift
// Holds the controller's reply byte and shifts it out MSB first on
// unpaused falling clock edges. A new byte is loaded on the first
// falling edge after a byte boundary; without a fresh load the held
// byte is sent again.
// Assumes: byte_end is the receive strobe, one pulse per byte.
module spi_tx_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              paused,
    input  logic              sck_fall,
    input  logic              byte_end,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              tx_req,
    output logic              miso,
    output logic              miso_oe,
    output logic              tx_taken
);

    logic [BYTE_W-1:0] hold_reg;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_reply;
    logic              boundary;
    logic              active;
    logic              fall_ok;

    assign fall_ok    = sck_fall & cs_act & ~paused;
    assign next_reply = tx_load ? tx_data : hold_reg;

    // Reply holding register written by the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_reg <= '0;
        end else if (tx_load) begin
            hold_reg <= tx_data;
        end
    end

    // Remember that a byte completed and a load is due
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boundary <= 1'b0;
        end else if (!cs_act) begin
            boundary <= 1'b0;
        end else if (byte_end) begin
            boundary <= 1'b1;
        end else if (fall_ok) begin
            boundary <= 1'b0;
        end
    end

    // Load or shift the reply on falling clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            active   <= 1'b0;
            tx_taken <= 1'b0;
        end else begin
            tx_taken <= 1'b0;
            if (!cs_act) begin
                active <= 1'b0;
            end else if (fall_ok) begin
                if (boundary) begin
                    active <= tx_req;
                    if (tx_req) begin
                        shreg    <= next_reply;
                        tx_taken <= 1'b1;
                    end
                end else if (active) begin
                    shreg <= {shreg[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso    = shreg[BYTE_W-1];
    assign miso_oe = active & cs_act & ~paused;

endmodule

// File: rtl/spi_target_fe.sv
// Module: spi_target_fe (top)
// Serial target front-end: synchronises the pins, applies the
// clock-qualified pause, assembles received bytes and serialises reply
// bytes. Command meaning is left to the downstream controller.
// Assumes: clk is at least four times the serial clock rate.
module spi_target_fe
    import spi_fe_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              hold_n,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              tx_req,
    output logic              miso,
    output logic              miso_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              xfer_start,
    output logic              xfer_abort,
    output logic              tx_taken
);

    pin_evt_t evt;
    logic     cs_act;
    logic     sck_lvl;
    logic     paused;

    assign cs_act  = evt.cs_act;
    assign sck_lvl = evt.sck_lvl;

    spi_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .mosi   (mosi),
        .hold_n (hold_n),
        .evt    (evt)
    );

    spi_hold_ctrl u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_lvl  (sck_lvl),
        .hold_act (evt.hold_act),
        .paused   (paused)
    );

    spi_rx_shift #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .cs_fall    (evt.cs_fall),
        .cs_rise    (evt.cs_rise),
        .sck_rise   (evt.sck_rise),
        .mosi_lvl   (evt.mosi_lvl),
        .paused     (paused),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .xfer_start (xfer_start),
        .xfer_abort (xfer_abort)
    );

    spi_tx_shift #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .paused   (paused),
        .sck_fall (evt.sck_fall),
        .byte_end (rx_valid),
        .tx_data  (tx_data),
        .tx_load  (tx_load),
        .tx_req   (tx_req),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .tx_taken (tx_taken)
    );

endmodule

// File: rtl/spi_target_fe_chk.sv
// Module: spi_target_fe_chk
// Temporal checks on the front-end, bound into every spi_target_fe.
// Assumes: connected to the top through the bind below.
module spi_target_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic sck_lvl,
    input logic paused,
    input logic miso_oe,
    input logic rx_valid,
    input logic rx_first,
    input logic xfer_start,
    input logic xfer_abort
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2
    AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first |-> rx_valid); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R4
    AST_OE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !miso_oe); // R8
    AST_NO_BYTE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !rx_valid); // R8
    AST_PAUSE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> !$past(sck_lvl)); // R9
    AST_UNPAUSE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) && $past(cs_act) |-> !$past(sck_lvl)); // R9
    AST_ABORT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> !$past(cs_act)); // R10
    AST_OE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !miso_oe); // R11
    AST_NO_BYTE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cs_act)); // R11

endmodule

bind spi_target_fe spi_target_fe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sck_lvl    (sck_lvl),
    .paused     (paused),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .rx_first   (rx_first),
    .xfer_start (xfer_start),
    .xfer_abort (xfer_abort)
);

// File: tb/spi_target_fe_bench.sv
// Scoreboard bench: the serial driver queues each expected received byte,
// a monitor pops and compares on every strobe. Reply bytes are rebuilt
// from miso and compared inside the driver.
module spi_target_fe_bench;

    localparam int HALF = 8;  // clk cycles per serial clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       hold_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic       tx_req = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_first;
    logic       xfer_start;
    logic       xfer_abort;
    logic       tx_taken;

    int         n_chk = 0;
    int         n_fail = 0;
    int         n_start = 0;
    int         n_abort = 0;
    int         n_taken = 0;
    logic       cpol = 1'b0;
    logic       done = 1'b0;
    logic [8:0] exp_q[$];
    logic [8:0] e;

    always #5 clk = ~clk;

    spi_target_fe u_spi_target_fe (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .hold_n     (hold_n),
        .tx_data    (tx_data),
        .tx_load    (tx_load),
        .tx_req     (tx_req),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .xfer_start (xfer_start),
        .xfer_abort (xfer_abort),
        .tx_taken   (tx_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: pop expected bytes on each strobe, count pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R2 actual=%0h expected=none", rx_byte);
                end else begin
                    e = exp_q.pop_front();
                    check("R2 byte", {24'd0, rx_byte}, {24'd0, e[7:0]});
                    check("R3 opcode flag", {31'd0, rx_first}, {31'd0, e[8]});
                end
            end
            if (xfer_start) n_start++;
            if (xfer_abort) n_abort++;
            if (tx_taken) n_taken++;
        end
    end

    task automatic load_reply(input logic [7:0] v);
        tx_data = v;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic cs_begin();
        sck = cpol;
        half();
        cs_n = 1'b0;
        half();
    endtask

    task automatic cs_end();
        half();
        cs_n = 1'b1;
        half();
        half();
        check("R11 oe off when deselected", {31'd0, miso_oe}, 32'd0);
    endtask

    // Wiggle pins while paused, then release with the clock high (R9)
    task automatic pause_body(input logic replying);
        for (int k = 0; k < 2; k++) begin
            sck = 1'b1;
            mosi = ~mosi;
            half();
            sck = 1'b0;
            half();
            check("R8 oe off while paused", {31'd0, miso_oe}, 32'd0);
        end
        sck = 1'b1;
        hold_n = 1'b1;
        half();
        check("R9 pause kept until clock low", {31'd0, miso_oe}, 32'd0);
        sck = 1'b0;
        half();
        check("R8 oe after resume", {31'd0, miso_oe}, {31'd0, replying});
    endtask

    // One full byte; optional pause before bit pause_bit, optional load
    task automatic spi_xfer(input logic [7:0] mo, input logic first,
                            input logic replying, input logic [7:0] exp_rep,
                            input int pause_bit, input int load_bit,
                            input logic [7:0] load_val);
        logic [7:0] mi;
        mi = 8'h00;
        exp_q.push_back({first, mo});
        for (int i = 7; i >= 0; i--) begin
            if (cpol) begin
                if (i == pause_bit) begin
                    hold_n = 1'b0;
                    half();
                    if (i != 7)
                        check("R9 no pause while clock high", {31'd0, miso_oe}, {31'd0, replying});
                    sck = 1'b0;
                    half();
                    check("R9 pause at clock low", {31'd0, miso_oe}, 32'd0);
                    pause_body(replying);
                end else begin
                    sck = 1'b0;
                end
            end else if (i == pause_bit) begin
                hold_n = 1'b0;
                half();
                check("R8 pause entered", {31'd0, miso_oe}, 32'd0);
                pause_body(replying);
            end
            mosi = mo[i];
            half();
            mi[i] = miso;
            check("R6 output enable", {31'd0, miso_oe}, {31'd0, replying});
            sck = 1'b1;
            half();
            if (i == load_bit) load_reply(load_val);
            if (!cpol) sck = 1'b0;
        end
        if (replying) check("R6 reply byte", {24'd0, mi}, {24'd0, exp_rep});
    endtask

    task automatic partial_bits(input logic [7:0] mo, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            if (cpol) sck = 1'b0;
            mosi = mo[i];
            half();
            sck = 1'b1;
            half();
            if (!cpol) sck = 1'b0;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int s0;
        int a0;
        int t0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R1 miso_oe", {31'd0, miso_oe}, 32'd0);
        check("R1 pulses", {28'd0, rx_first, xfer_start, xfer_abort, tx_taken}, 32'd0);
        rst_n = 1'b1;
        half();

        // R5/R6/R7: idle-low clock, replies with repeat and fresh load
        cpol = 1'b0;
        tx_req = 1'b1;
        load_reply(8'hA5);
        s0 = n_start; t0 = n_taken; a0 = n_abort;
        cs_begin();
        spi_xfer(8'h9F, 1'b1, 1'b0, 8'h00, -1, -1, 8'h00);
        spi_xfer(8'h12, 1'b0, 1'b1, 8'hA5, -1, -1, 8'h00);
        spi_xfer(8'hC3, 1'b0, 1'b1, 8'hA5, -1, 4, 8'h3C); // R7 repeat
        spi_xfer(8'h00, 1'b0, 1'b1, 8'h3C, -1, -1, 8'h00);
        cs_end();
        check("R4 one start pulse", n_start - s0, 32'd1);
        check("R6 loads at each boundary", n_taken - t0, 32'd4);
        check("R10 no abort on clean end", n_abort - a0, 32'd0);

        // R5: idle-high clock, same flow
        cpol = 1'b1;
        load_reply(8'h5A);
        s0 = n_start; t0 = n_taken;
        cs_begin();
        spi_xfer(8'h0B, 1'b1, 1'b0, 8'h00, -1, -1, 8'h00);
        spi_xfer(8'hF0, 1'b0, 1'b1, 8'h5A, -1, -1, 8'h00);
        spi_xfer(8'h0F, 1'b0, 1'b1, 8'h5A, -1, 2, 8'h66);
        spi_xfer(8'hE7, 1'b0, 1'b1, 8'h66, -1, -1, 8'h00);
        cs_end();
        check("R4 start in idle-high", n_start - s0, 32'd1);
        check("R5 loads without trailing fall", n_taken - t0, 32'd3);

        // R8: pauses with clock low, idle-low mode
        cpol = 1'b0;
        load_reply(8'hC7);
        cs_begin();
        spi_xfer(8'h03, 1'b1, 1'b0, 8'h00, 2, -1, 8'h00);
        spi_xfer(8'hE1, 1'b0, 1'b1, 8'hC7, 3, -1, 8'h00);
        cs_end();

        // R9: pause requested with clock high, idle-high mode
        cpol = 1'b1;
        load_reply(8'h39);
        cs_begin();
        spi_xfer(8'h02, 1'b1, 1'b0, 8'h00, 6, -1, 8'h00);
        spi_xfer(8'h7E, 1'b0, 1'b1, 8'h39, 7, -1, 8'h00);
        spi_xfer(8'h81, 1'b0, 1'b1, 8'h39, 0, -1, 8'h00);
        cs_end();

        // R10: deselect while paused, then a fresh selection
        cpol = 1'b0;
        tx_req = 1'b0;
        a0 = n_abort;
        cs_begin();
        partial_bits(8'hFF, 3);
        hold_n = 1'b0;
        half();
        check("R8 oe off in pause", {31'd0, miso_oe}, 32'd0);
        cs_n = 1'b1;
        half();
        half();
        check("R10 abort while paused", n_abort - a0, 32'd1);
        hold_n = 1'b1;
        half();
        cs_begin();
        spi_xfer(8'h5A, 1'b1, 1'b0, 8'h00, -1, -1, 8'h00);
        spi_xfer(8'hA3, 1'b0, 1'b0, 8'h00, -1, -1, 8'h00); // R6 no request
        cs_end();

        // R10: deselect with a partial byte
        a0 = n_abort;
        cs_begin();
        partial_bits(8'h00, 5);
        cs_end();
        check("R10 abort on partial byte", n_abort - a0, 32'd1);
        cs_begin();
        spi_xfer(8'hC3, 1'b1, 1'b0, 8'h00, -1, -1, 8'h00);
        cs_end();
        check("R10 clean end after restart", n_abort - a0, 32'd1);

        half();
        check("R2 every byte delivered", exp_q.size(), 32'd0);
        done = 1'b1;
        finish_run();
    end

endmodule